// File: doc/BRIEF.md
# Error-Corrected Framed Serial Line Transmitter

This block turns a byte stream held in a transmission buffer into a continuous serial line signal made of fixed-length protected frames. Each frame opens with one alignment bit and one fill indicator. These are followed by a payload section and an 18-bit parity field of a (511,493) BCH code, so a frame is 512 bits long. The parity covers the fill indicator and the payload. All logic runs on the line clock that the receiver supplies. Every change on the outputs happens on a falling edge of that clock, so the receiver can sample on the rising edge.

At each frame start the block checks the buffer fill level. The check counts in 16-byte units, so there is no exact threshold. If the level cannot guarantee a complete payload, the frame goes out as a fill frame. A control input can also force fill frames. That input is only looked at on frame boundaries. A one-period pulse marks the start of every fill frame, so software can count fill frames.

The receiver gates the line with two inputs, a clear level and a ready level. Tying the clear input low gives a plain serial link that is always ready. A second control input turns framing off. In that test mode the raw buffer bytes go out back to back.

Top module: `fec_line_tx`

## Requirements
- R1: While `rst_n` is low, `line_idle` and `ser_data` are 1, and `fill_pulse` and `rd_pop` are 0.
- R2: The receiver is ready when `rx_clear` is 0 or `rx_ready` is 1. `line_idle` stays 1 until the first falling edge at which the receiver is ready, and falls at that edge. After that it stays 0 until the next reset. No payload bit is sent while `line_idle` is 1, and `ser_data` is 1 during that time.
- R3: With `frame_en`=1, each falling edge after `line_idle` is low and with the receiver ready sends the next bit of a 512-bit frame, in this order: alignment bit, fill indicator, 492 payload bits, 18 parity bits.
- R4: The alignment bits of successive frames repeat the sequence 0,0,0,1,1,0,1,1, beginning at the first frame after reset.
- R5: A data frame has fill indicator 1. Its payload bits are the buffer bytes taken most significant bit first, and the stream continues across frame boundaries. After the falling edge that sends the last bit of a byte, `rd_pop` is 1 for one line-clock period. `rd_byte` shows the head byte of the buffer.
- R6: A frame is a fill frame when, at its alignment bit, `buf_level` (a byte count) shifted right by 4 is below 4. A fill frame has fill indicator 0 and 492 payload bits of 1, and it pops no bytes.
- R7: The parity field is the remainder of (fill indicator and payload, first bit as highest power) times x^18, divided by g(x) = x^18+x^15+x^12+x^10+x^8+x^7+x^6+x^3+1. It is sent highest coefficient first.
- R8: `force_fill` is sampled only at a frame's alignment bit. A frame already in progress is not affected by it, and every frame that starts while it is 1 is a fill frame.
- R9: `fill_pulse` is 1 for exactly the line-clock period that follows the alignment bit of a fill frame, and is 0 at all other times.
- R10: On a falling edge at which the receiver is not ready, `ser_data` holds its value and no bit is consumed. `rd_pop` and `fill_pulse` are 0 after that edge. Sending resumes with the next bit of the sequence.
- R11: With `frame_en`=0, each sending edge outputs the next buffer bit, most significant bit of each byte first, while `buf_level` is nonzero, and outputs 1 when it is zero. No framing, parity or `fill_pulse` is produced in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| line_clk | input | 1 | Line clock from the receiver; the logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_clear | input | 1 | Receiver clear level; 0 means ready |
| rx_ready | input | 1 | Receiver ready level; 1 means ready |
| frame_en | input | 1 | 1 sends protected frames, 0 sends raw bytes |
| force_fill | input | 1 | Forces fill frames from the next frame start |
| buf_level | input | LEVEL_W | Number of bytes held in the buffer |
| rd_byte | input | 8 | Head byte of the buffer |
| ser_data | output | 1 | Serial data, changes on falling edges |
| line_idle | output | 1 | High until the receiver first becomes ready |
| fill_pulse | output | 1 | One-period pulse at the start of each fill frame |
| rd_pop | output | 1 | One-period request to drop the head byte |

## Verification
The bench first lets the buffer drain through three data frames into automatic fill frames. This shows whether the 16-byte-unit level decision and the continuous byte order across frame boundaries are right. It then raises the level and toggles the force input in the middle of frames. This separates a design that samples force only at the alignment bit from one that reacts within the frame. During a data frame the bench stalls the receiver and then makes it ready through each of its two inputs in turn, which exposes lost or repeated bits. After a second reset, raw mode with a nearly empty buffer shows whether the design switches correctly between byte bits and idle ones.

// File: rtl/fec_line_pkg.sv
`timescale 1ns/1ps
package fec_line_pkg;
   typedef enum logic [1:0] {PH_ALIGN, PH_IND, PH_DATA, PH_PAR} phase_e;
   typedef enum logic [1:0] {PAR_HOLD, PAR_CLEAR, PAR_FEED, PAR_SHIFT} par_op_e;
endpackage

// File: rtl/fec_line_hs.sv
`timescale 1ns/1ps
// Receiver handshake: idle until first ready edge, then advance on every ready edge
module fec_line_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_clear,
   input  logic rx_ready,
   output logic line_idle,
   output logic adv
);
   logic rx_ok;
   assign rx_ok = ~rx_clear | rx_ready;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         line_idle <= 1'b1;
      else if (rx_ok)
         line_idle <= 1'b0;
   end

   assign adv = rx_ok & ~line_idle;
endmodule

// File: rtl/fec_line_parity.sv
`timescale 1ns/1ps
// Bit-serial systematic remainder generator
module fec_line_parity
   import fec_line_pkg::*;
#(
   parameter int                  PAR_BITS = 18,
   parameter logic [PAR_BITS-1:0] PAR_POLY = 18'h095C9
) (
   input  logic    clk,
   input  logic    rst_n,
   input  par_op_e op,
   input  logic    bit_in,
   output logic    par_msb
);
   logic [PAR_BITS-1:0] rem_q;
   logic [PAR_BITS-1:0] rem_feed;
   logic                fb;

   assign fb = bit_in ^ rem_q[PAR_BITS-1];

   for (genvar i = 0; i < PAR_BITS; i++) begin : g_tap
      if (i == 0) begin : g_lo
         assign rem_feed[i] = fb & PAR_POLY[i];
      end else begin : g_hi
         assign rem_feed[i] = rem_q[i-1] ^ (fb & PAR_POLY[i]);
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else begin
         case (op)
            PAR_CLEAR: rem_q <= '0;
            PAR_FEED:  rem_q <= rem_feed;
            PAR_SHIFT: rem_q <= {rem_q[PAR_BITS-2:0], 1'b0};
            default:   rem_q <= rem_q;
         endcase
      end
   end

   assign par_msb = rem_q[PAR_BITS-1];
endmodule

// File: rtl/fec_line_seq.sv
`timescale 1ns/1ps
// Frame position, alignment sequence, fill decision and byte walking
module fec_line_seq
   import fec_line_pkg::*;
#(
   parameter int                   DATA_BITS     = 492,
   parameter int                   PAR_BITS      = 18,
   parameter int                   LEVEL_W       = 16,
   parameter int                   UNIT_SHIFT    = 4,
   parameter int                   ALIGN_LEN     = 8,
   parameter logic [ALIGN_LEN-1:0] ALIGN_PATTERN = 8'b00011011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               frame_en,
   input  logic               force_fill,
   input  logic [LEVEL_W-1:0] buf_level,
   output phase_e             phase,
   output logic               fill_q,
   output logic [2:0]         bit_idx,
   output logic               align_bit,
   output logic               has_bytes,
   output logic               pop_q,
   output logic               pulse_q
);
   localparam int FRAME_BITS = 2 + DATA_BITS + PAR_BITS;
   localparam int POS_W      = $clog2(FRAME_BITS);
   localparam int DATA_END   = 2 + DATA_BITS;
   localparam int NEED_BYTES = (DATA_BITS + 14) / 8;  // worst case with a partly used head byte
   localparam int UNIT_BYTES = 1 << UNIT_SHIFT;
   localparam int NEED_UNITS = (NEED_BYTES + UNIT_BYTES - 1) / UNIT_BYTES;
   localparam int AL_W       = $clog2(ALIGN_LEN);

   logic [POS_W-1:0] pos;
   logic [AL_W-1:0]  al_idx;
   logic             low_level, fill_now, consume;

   always_comb begin
      if (pos == '0)                      phase = PH_ALIGN;
      else if (pos == POS_W'(1))          phase = PH_IND;
      else if (pos < POS_W'(DATA_END))    phase = PH_DATA;
      else                                phase = PH_PAR;
   end

   assign has_bytes = |buf_level;
   assign low_level = (buf_level >> UNIT_SHIFT) < LEVEL_W'(NEED_UNITS);
   assign fill_now  = force_fill | low_level;
   assign consume   = adv & (frame_en ? (phase == PH_DATA && !fill_q) : has_bytes);
   assign align_bit = ALIGN_PATTERN[AL_W'(ALIGN_LEN-1) - al_idx];

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         al_idx  <= '0;
         fill_q  <= 1'b0;
         bit_idx <= 3'd0;
         pop_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         pop_q   <= 1'b0;
         if (adv) begin
            if (!frame_en)
               pos <= '0;
            else begin
               pos <= (pos == POS_W'(FRAME_BITS-1)) ? '0 : pos + POS_W'(1);
               if (phase == PH_ALIGN) begin
                  fill_q  <= fill_now;
                  pulse_q <= fill_now;
                  al_idx  <= (al_idx == AL_W'(ALIGN_LEN-1)) ? '0 : al_idx + AL_W'(1);
               end
            end
         end
         if (consume) begin
            bit_idx <= bit_idx + 3'd1;
            pop_q   <= (bit_idx == 3'd7);
         end
      end
   end
endmodule

// File: rtl/fec_line_tx.sv
`timescale 1ns/1ps
module fec_line_tx
   import fec_line_pkg::*;
#(
   parameter int                   DATA_BITS     = 492,
   parameter int                   PAR_BITS      = 18,
   parameter logic [PAR_BITS-1:0]  PAR_POLY      = 18'h095C9,
   parameter int                   LEVEL_W       = 16,
   parameter int                   UNIT_SHIFT    = 4,
   parameter int                   ALIGN_LEN     = 8,
   parameter logic [ALIGN_LEN-1:0] ALIGN_PATTERN = 8'b00011011
) (
   input  logic               line_clk,
   input  logic               rst_n,
   input  logic               rx_clear,
   input  logic               rx_ready,
   input  logic               frame_en,
   input  logic               force_fill,
   input  logic [LEVEL_W-1:0] buf_level,
   input  logic [7:0]         rd_byte,
   output logic               ser_data,
   output logic               line_idle,
   output logic               fill_pulse,
   output logic               rd_pop
);
   if (PAR_BITS < 2) begin : g_bad_par
      $error("PAR_BITS must be at least 2");
   end
   if (ALIGN_LEN < 2) begin : g_bad_align
      $error("ALIGN_LEN must be at least 2");
   end
   if (LEVEL_W <= UNIT_SHIFT) begin : g_bad_level
      $error("LEVEL_W must exceed UNIT_SHIFT");
   end

   logic       adv, fill_q, align_bit, has_bytes, pop_q, pulse_q, par_msb;
   logic       byte_bit, nxt_bit, tx_q;
   logic [2:0] bit_idx;
   phase_e     phase;
   par_op_e    par_op;

   fec_line_hs u_hs (
      .clk(line_clk), .rst_n(rst_n), .rx_clear(rx_clear), .rx_ready(rx_ready),
      .line_idle(line_idle), .adv(adv)
   );

   fec_line_seq #(
      .DATA_BITS(DATA_BITS), .PAR_BITS(PAR_BITS), .LEVEL_W(LEVEL_W),
      .UNIT_SHIFT(UNIT_SHIFT), .ALIGN_LEN(ALIGN_LEN), .ALIGN_PATTERN(ALIGN_PATTERN)
   ) u_seq (
      .clk(line_clk), .rst_n(rst_n), .adv(adv), .frame_en(frame_en),
      .force_fill(force_fill), .buf_level(buf_level), .phase(phase),
      .fill_q(fill_q), .bit_idx(bit_idx), .align_bit(align_bit),
      .has_bytes(has_bytes), .pop_q(pop_q), .pulse_q(pulse_q)
   );

   fec_line_parity #(.PAR_BITS(PAR_BITS), .PAR_POLY(PAR_POLY)) u_par (
      .clk(line_clk), .rst_n(rst_n), .op(par_op), .bit_in(nxt_bit), .par_msb(par_msb)
   );

   always_comb begin
      byte_bit = rd_byte[3'd7 - bit_idx];
      if (!frame_en)
         nxt_bit = has_bytes ? byte_bit : 1'b1;
      else begin
         case (phase)
            PH_ALIGN: nxt_bit = align_bit;
            PH_IND:   nxt_bit = ~fill_q;
            PH_DATA:  nxt_bit = fill_q ? 1'b1 : byte_bit;
            default:  nxt_bit = par_msb;
         endcase
      end
   end

   always_comb begin
      par_op = PAR_HOLD;
      if (adv && frame_en) begin
         case (phase)
            PH_ALIGN:        par_op = PAR_CLEAR;
            PH_IND, PH_DATA: par_op = PAR_FEED;
            default:         par_op = PAR_SHIFT;
         endcase
      end
   end

   always_ff @(negedge line_clk or negedge rst_n) begin
      if (!rst_n)
         tx_q <= 1'b1;
      else if (adv)
         tx_q <= nxt_bit;
   end

   assign ser_data   = tx_q;
   assign fill_pulse = pulse_q;
   assign rd_pop     = pop_q;
endmodule

// File: rtl/fec_line_tx_chk.sv
`timescale 1ns/1ps
module fec_line_tx_chk (
   input logic line_clk,
   input logic rst_n,
   input logic rx_clear,
   input logic rx_ready,
   input logic frame_en,
   input logic line_idle,
   input logic ser_data,
   input logic fill_pulse,
   input logic rd_pop
);
   logic ok_rx;
   assign ok_rx = ~rx_clear | rx_ready;

   // R2
   p_idle_sticky_r2: assert property (@(negedge line_clk) disable iff (!rst_n)
      !line_idle |=> !line_idle);
   // R2
   p_idle_waits_r2: assert property (@(negedge line_clk) disable iff (!rst_n)
      (line_idle && !ok_rx) |=> line_idle);
   // R2
   p_idle_no_data_r2: assert property (@(negedge line_clk) disable iff (!rst_n)
      line_idle |-> ser_data);
   // R10
   p_stall_hold_r10: assert property (@(negedge line_clk) disable iff (!rst_n)
      !ok_rx |=> ($stable(ser_data) && !rd_pop && !fill_pulse));
   // R9
   p_pulse_single_r9: assert property (@(negedge line_clk) disable iff (!rst_n)
      fill_pulse |=> !fill_pulse);
   // R5
   p_pop_single_r5: assert property (@(negedge line_clk) disable iff (!rst_n)
      rd_pop |=> !rd_pop);
   // R11
   p_raw_no_pulse_r11: assert property (@(negedge line_clk) disable iff (!rst_n)
      !frame_en |=> !fill_pulse);
endmodule

bind fec_line_tx fec_line_tx_chk u_chk (
   .line_clk(line_clk), .rst_n(rst_n), .rx_clear(rx_clear), .rx_ready(rx_ready),
   .frame_en(frame_en), .line_idle(line_idle), .ser_data(ser_data),
   .fill_pulse(fill_pulse), .rd_pop(rd_pop)
);

// File: tb/fec_line_tx_tb_top.sv
`timescale 1ns/1ps
module fec_line_tx_tb_top;
   logic        line_clk = 1'b0;
   logic        rst_n    = 1'b0;
   logic        rx_clear = 1'b1;
   logic        rx_ready = 1'b0;
   logic        frame_en = 1'b1;
   logic        force_fill = 1'b0;
   logic [15:0] buf_level;
   logic [7:0]  rd_byte;
   logic        ser_data, line_idle, fill_pulse, rd_pop;

   always #5 line_clk = ~line_clk;

   fec_line_tx dut_i (
      .line_clk(line_clk), .rst_n(rst_n), .rx_clear(rx_clear), .rx_ready(rx_ready),
      .frame_en(frame_en), .force_fill(force_fill), .buf_level(buf_level),
      .rd_byte(rd_byte), .ser_data(ser_data), .line_idle(line_idle),
      .fill_pulse(fill_pulse), .rd_pop(rd_pop)
   );

   localparam logic [18:0] GEN = 19'h495C9;  // R7 generator incl. x^18
   localparam logic [7:0]  ALIGN_SEQ = 8'b00011011;  // R4

   typedef struct {
      logic b;
      logic pulse;
      logic pop;
      int   req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_err = 0;
   int   avail = 0, head = 0, bitp = 0, fcount = 0, emit_cnt = 0;
   bit   mon_on = 1'b0, done = 1'b0;
   logic idle_prev = 1'b1, last_bit = 1'b1, cur_ready, emitted;

   function automatic logic [7:0] byte_at(int i);
      return 8'((i * 37 + 11) ^ (i >> 3));
   endfunction

   assign rd_byte   = byte_at(head);
   assign buf_level = 16'((avail > head) ? avail - head : 0);

   // buffer model: pops on the rising edge between two sending edges
   always @(posedge line_clk or negedge rst_n)
      if (!rst_n) head <= 0;
      else if (rd_pop) head <= head + 1;

   task automatic chk(input bit ok, input int req, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL R%0d: actual=%0d expected=%0d (emit %0d)", req, act, exp_v, emit_cnt);
      end
   endtask

   task automatic push(input logic b, input logic pulse, input logic pop, input int req);
      exp_t e;
      e.b = b; e.pulse = pulse; e.pop = pop; e.req = req;
      exp_q.push_back(e);
   endtask

   // driver: expected frame from requirements R3..R9
   task automatic build_frame();
      logic [510:0] w;
      logic         fill, low, b;
      int           tag;
      low  = (((avail - bitp / 8) >> 4) < 4);            // R6
      fill = low || force_fill;                           // R8
      tag  = fill ? (low ? 6 : 8) : 5;
      w    = '0;
      push(ALIGN_SEQ[7 - (fcount % 8)], fill, 1'b0, 4);   // R4, R9 pulse
      push(~fill, 1'b0, 1'b0, 3);                         // R3 indicator
      w[510] = ~fill;
      for (int k = 0; k < 492; k++) begin
         if (fill) begin
            b = 1'b1;
            push(b, 1'b0, 1'b0, tag);
         end else begin
            b = byte_at(bitp / 8)[7 - (bitp % 8)];
            push(b, 1'b0, (bitp % 8) == 7, tag);          // R5
            bitp++;
         end
         w[509 - k] = b;
      end
      for (int d = 510; d >= 18; d--)
         if (w[d]) w[d -: 19] = w[d -: 19] ^ GEN;
      for (int p = 17; p >= 0; p--)
         push(w[p], 1'b0, 1'b0, 7);                       // R7
      fcount++;
   endtask

   task automatic build_raw();                            // R11
      if (avail - bitp / 8 > 0) begin
         push(byte_at(bitp / 8)[7 - (bitp % 8)], 1'b0, (bitp % 8) == 7, 11);
         bitp++;
      end else
         push(1'b1, 1'b0, 1'b0, 11);
   endtask

   // monitor: samples at the rising edge, half a period after outputs move
   always @(posedge line_clk) begin
      exp_t it;
      if (mon_on) begin
         cur_ready = !rx_clear || rx_ready;
         emitted   = cur_ready && !idle_prev;
         chk(line_idle == (idle_prev && !cur_ready), 2, line_idle, idle_prev && !cur_ready); // R2
         if (emitted) begin
            if (exp_q.size() == 0) begin
               if (frame_en) build_frame(); else build_raw();
            end
            it = exp_q.pop_front();
            chk(ser_data == it.b, it.req, ser_data, it.b);
            chk(fill_pulse == it.pulse, 9, fill_pulse, it.pulse);       // R9
            chk(rd_pop == it.pop, (it.req == 11) ? 11 : 5, rd_pop, it.pop);
            last_bit = it.b;
            emit_cnt++;
         end else begin
            chk(ser_data == last_bit, 10, ser_data, last_bit);          // R10
            chk(!rd_pop && !fill_pulse, 10, {rd_pop, fill_pulse}, 0);   // R10
         end
         idle_prev = line_idle;
      end else begin
         idle_prev = 1'b1;
         last_bit  = 1'b1;
      end
   end

   task automatic wait_emits(input int n);
      do @(posedge line_clk); while (emit_cnt < n);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge line_clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      avail = 200;
      repeat (3) @(posedge line_clk);
      // R1 reset state
      chk(line_idle == 1'b1, 1, line_idle, 1);
      chk(ser_data == 1'b1, 1, ser_data, 1);
      chk(fill_pulse == 1'b0, 1, fill_pulse, 0);
      chk(rd_pop == 1'b0, 1, rd_pop, 0);
      #1; rst_n = 1'b1; mon_on = 1'b1;
      repeat (5) @(posedge line_clk);              // R2 receiver not ready
      #1; rx_clear = 1'b0;                          // plain serial ready
      wait_emits(700);                              // R10 stall in data frame 1
      rx_clear = 1'b1; rx_ready = 1'b0;
      repeat (6) @(posedge line_clk);
      #1; rx_ready = 1'b1;                          // ready through rx_ready
      repeat (20) @(posedge line_clk);
      #1; rx_clear = 1'b0; rx_ready = 1'b0;
      wait_emits(2200);                             // frames 3,4 filled automatically (R6)
      avail = 600; force_fill = 1'b1;               // R8 frame 5 forced
      wait_emits(2800);
      force_fill = 1'b0;                            // frame 6 data
      wait_emits(3200);
      force_fill = 1'b1;                            // frame 6 unaffected, frame 7 forced
      wait_emits(3700);
      force_fill = 1'b0;                            // frame 8 data
      wait_emits(4700);
      chk(fcount == 10, 4, fcount, 10);             // R4 frames built
      // raw test mode after a fresh reset (R11)
      mon_on = 1'b0; rst_n = 1'b0;
      exp_q.delete();
      bitp = 0; fcount = 0; frame_en = 1'b0; avail = 3;
      repeat (3) @(posedge line_clk);
      #1; rst_n = 1'b1; mon_on = 1'b1;
      wait_emits(emit_cnt + 40);
      avail = 5;
      wait_emits(emit_cnt + 40);
      chk(head == 5, 11, head, 5);                  // R11 bytes consumed
      finish_run();
   end
endmodule